// File: doc/BRIEF.md
# Timed Signature Row Read Controller

This block is the read side of a self-programming control unit. It lets software fetch a small, fixed identification and calibration row through the ordinary program-memory load path. Software first writes a control register with two bits set, an enable bit and a signature-select bit. The controller then stays armed for a short, fixed number of cycles. A program-memory load issued while the controller is armed does not return the flash word. It returns the signature-row byte that the load pointer selects.

The arming bits clear themselves in two cases. They clear as soon as one redirected load has been served. They also clear when the window runs out with no load. The enable bit can be read back, so software uses it as a busy flag and waits for it to read zero before it starts a new operation. When the controller is not armed, every load returns the flash-array data presented with it.

Load results are registered. The returned byte and a valid strobe appear on the cycle after the load request.

Top module: `sigrow_read_ctrl`

## Requirements
- R1: A register write with bit 0 (enable) and bit 1 (signature-select) both set, made while the controller is idle, arms it. From the next cycle the register reads back 8'h03. When the controller is idle the register reads 8'h00, and bits 7:2 always read 0.
- R2: A load requested while the controller is armed is answered on the next cycle with `ld_valid`=1 and `ld_rdata` set to the signature byte decoded from `ld_addr`. `flash_rdata` is ignored for that load.
- R3: A redirected load clears both control bits, so the register reads 8'h00 from the cycle after the load.
- R4: If no load arrives inside the window, both bits clear on their own and the register reads 8'h00.
- R5: A load requested while the controller is not armed returns, on the next cycle, the `flash_rdata` value presented with it, with `ld_valid`=1.
- R6: The enable bit reads 1 on every cycle of the window, and the signature-select bit always reads the same value as the enable bit.
- R7: Pointer addresses 16'h0000, 16'h0002 and 16'h0004 return device identity bytes 1, 2 and 3 (defaults 8'h1E, 8'h95, 8'h02).
- R8: Pointer address 16'h0001 returns the oscillator trim byte (default 8'h9A), 16'h0005 the temperature offset byte (default 8'h37), and 16'h0007 the temperature gain byte (default 8'h84).
- R9: An armed load from any other address returns 8'hFF and still clears both bits.
- R10: The window opens on the cycle after the arming write and spans 3 cycles. A load on the third of these cycles is still redirected, and a load on the fourth returns flash data.
- R11: A write that does not set both bit 0 and bit 1 has no effect. The register stays 8'h00 and the next load returns flash data.
- R12: Writes made while the enable bit is set are ignored. They neither clear the window nor restart it.
- R13: A load in the same cycle as the arming write is not redirected. It returns flash data, and the window still opens on the next cycle.
- R14: After reset the register reads 8'h00, `ld_valid` is 0 and `ld_rdata` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| ld_req | input | 1 | Program-memory load request |
| ld_addr | input | 16 | Load pointer address |
| flash_rdata | input | 8 | Flash array byte for the requested address |
| ld_valid | output | 1 | Load result strobe, one cycle after `ld_req` |
| ld_rdata | output | 8 | Load result byte |

## Verification
Three kinds of event can collide in one cycle. A load can arrive on the same cycle that the window expires. A load can arrive on the same cycle as the arming register write. A register write can arrive in the middle of an open window. The bench provokes each collision by placing the load or the write on an exact cycle counted from the arming write: on the third cycle of the window, in the cycle of the write itself, and on the first cycle of the window. A behavioural model tracks whether the controller is armed and how old the window is, and every clock it judges the returned byte and the register value against that model.

// File: rtl/sigrow_pkg.sv
package sigrow_pkg;

    localparam int CTRL_W    = 8;
    localparam int EN_BIT    = 0;
    localparam int SIG_BIT   = 1;
    localparam int PTR_W     = 16;
    localparam int BYTE_W    = 8;

    typedef enum logic [2:0] {
        SEL_ID1,
        SEL_ID2,
        SEL_ID3,
        SEL_TRIM,
        SEL_TOFF,
        SEL_TGAIN,
        SEL_NONE
    } sig_sel_e;

    typedef struct packed {
        logic valid;
        logic [BYTE_W-1:0] data;
    } ld_out_t;

endpackage

// File: rtl/sigrow_window.sv
module sigrow_window #(
    parameter int WINDOW = 3,
    localparam int CW    = $clog2(WINDOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wr_en_i,
    input  logic wr_sig_i,
    input  logic consume_i,
    output logic en_o,
    output logic sig_o
);

    typedef struct packed {
        logic en;
        logic sig;
        logic [CW-1:0] age;
    } win_t;

    localparam logic [CW-1:0] AGE_LAST = CW'(WINDOW);
    localparam logic [CW-1:0] AGE_ONE  = CW'(1);

    win_t st_d, st_q;
    logic arm_req;

    assign arm_req = wr_i && wr_en_i && wr_sig_i && !st_q.en;

    always_comb begin
        st_d = st_q;
        if (st_q.en) begin
            if (consume_i || (st_q.age == AGE_LAST)) begin
                st_d.en  = 1'b0;
                st_d.sig = 1'b0;
                st_d.age = '0;
            end else begin
                st_d.age = st_q.age + AGE_ONE;
            end
        end else if (arm_req) begin
            st_d.en  = 1'b1;
            st_d.sig = 1'b1;
            st_d.age = AGE_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign sig_o = st_q.sig;

    a_r3_clear_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && consume_i) |=> !st_q.en);

    a_r4_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && !consume_i && st_q.age == AGE_LAST) |=> (!st_q.en && !st_q.sig));

    a_r6_bits_together: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en == st_q.sig);

    a_r10_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |-> (st_q.age >= AGE_ONE && st_q.age <= AGE_LAST));

    a_r11_partial_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && wr_i && !(wr_en_i && wr_sig_i)) |=> !st_q.en);

    a_r12_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && wr_i && !consume_i && st_q.age != AGE_LAST) |=> (st_q.age == $past(st_q.age) + AGE_ONE));

endmodule

// File: rtl/sigrow_decode.sv
module sigrow_decode
    import sigrow_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID1   = 8'h1E,
    parameter logic [BYTE_W-1:0] ID2   = 8'h95,
    parameter logic [BYTE_W-1:0] ID3   = 8'h02,
    parameter logic [BYTE_W-1:0] TRIM  = 8'h9A,
    parameter logic [BYTE_W-1:0] TOFF  = 8'h37,
    parameter logic [BYTE_W-1:0] TGAIN = 8'h84
) (
    input  logic [PTR_W-1:0]  addr_i,
    output logic              hit_o,
    output logic [BYTE_W-1:0] byte_o
);

    sig_sel_e sel;

    always_comb begin
        unique case (addr_i)
            16'h0000: sel = SEL_ID1;
            16'h0002: sel = SEL_ID2;
            16'h0004: sel = SEL_ID3;
            16'h0001: sel = SEL_TRIM;
            16'h0005: sel = SEL_TOFF;
            16'h0007: sel = SEL_TGAIN;
            default:  sel = SEL_NONE;
        endcase
    end

    always_comb begin
        hit_o = 1'b1;
        unique case (sel)
            SEL_ID1:   byte_o = ID1;
            SEL_ID2:   byte_o = ID2;
            SEL_ID3:   byte_o = ID3;
            SEL_TRIM:  byte_o = TRIM;
            SEL_TOFF:  byte_o = TOFF;
            SEL_TGAIN: byte_o = TGAIN;
            default: begin
                byte_o = '1;
                hit_o  = 1'b0;
            end
        endcase
    end

    always_comb begin
        a_r9_reserved_ff: assert (hit_o || byte_o == '1);
    end

endmodule

// File: rtl/sigrow_read_ctrl.sv
module sigrow_read_ctrl
    import sigrow_pkg::*;
#(
    parameter int WINDOW = 3,
    parameter logic [7:0] ID1   = 8'h1E,
    parameter logic [7:0] ID2   = 8'h95,
    parameter logic [7:0] ID3   = 8'h02,
    parameter logic [7:0] TRIM  = 8'h9A,
    parameter logic [7:0] TOFF  = 8'h37,
    parameter logic [7:0] TGAIN = 8'h84
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        ld_req,
    input  logic [15:0] ld_addr,
    input  logic [7:0]  flash_rdata,
    output logic        ld_valid,
    output logic [7:0]  ld_rdata
);

    logic armed_en, armed_sig;
    logic dec_hit;
    logic [BYTE_W-1:0] dec_byte;
    logic consume;
    ld_out_t out_d, out_q;

    assign consume = ld_req && armed_en && armed_sig;

    sigrow_window #(.WINDOW(WINDOW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .wr_en_i   (reg_wdata[EN_BIT]),
        .wr_sig_i  (reg_wdata[SIG_BIT]),
        .consume_i (consume),
        .en_o      (armed_en),
        .sig_o     (armed_sig)
    );

    sigrow_decode #(
        .ID1(ID1), .ID2(ID2), .ID3(ID3),
        .TRIM(TRIM), .TOFF(TOFF), .TGAIN(TGAIN)
    ) u_decode (
        .addr_i (ld_addr),
        .hit_o  (dec_hit),
        .byte_o (dec_byte)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = ld_req;
        if (ld_req) begin
            out_d.data = consume ? dec_byte : flash_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[EN_BIT]  = armed_en;
        reg_rdata[SIG_BIT] = armed_sig;
    end

    assign ld_valid = out_q.valid;
    assign ld_rdata = out_q.data;

    a_r1_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[EN_BIT] && reg_wdata[SIG_BIT] && reg_rdata == 8'h00) |=> (reg_rdata == 8'h03));

    a_r5_flash_path: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && reg_rdata == 8'h00) |=> (ld_valid && ld_rdata == $past(flash_rdata)));

    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> ld_valid);

    a_r9_reserved_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && reg_rdata == 8'h03 && !dec_hit) |=> (ld_rdata == 8'hFF && reg_rdata == 8'h00));

endmodule

// File: tb/sigrow_read_ctrl_tb.sv
module sigrow_read_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ld_req = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [7:0]  flash_rdata = '0;
    logic        ld_valid;
    logic [7:0]  ld_rdata;

    int checks = 0;
    int errors = 0;
    int m_armed = 0;
    int m_age = 0;
    int e_valid = 0;
    int e_data = 0;

    always #2.5 clk = ~clk;

    sigrow_read_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ld_req(ld_req), .ld_addr(ld_addr),
        .flash_rdata(flash_rdata), .ld_valid(ld_valid), .ld_rdata(ld_rdata)
    );

    function automatic int sig_byte(input int a);
        case (a)
            0: return 8'h1E;
            2: return 8'h95;
            4: return 8'h02;
            1: return 8'h9A;
            5: return 8'h37;
            7: return 8'h84;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input bit wr, input int wd, input bit ld,
                        input int addr, input int fd);
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd[7:0];
        ld_req = ld; ld_addr = addr[15:0]; flash_rdata = fd[7:0];
        e_valid = ld;
        if (ld) e_data = (m_armed != 0) ? sig_byte(addr) : fd;
        if (m_armed != 0) begin
            if (ld || m_age == 3) begin m_armed = 0; m_age = 0; end
            else m_age++;
        end else if (wr && wd[1:0] == 2'b11) begin
            m_armed = 1; m_age = 1;
        end
        @(posedge clk);
        #1;
        check(req, "reg", int'(reg_rdata), (m_armed != 0) ? 8'h03 : 8'h00);
        check(req, "valid", int'(ld_valid), e_valid);
        if (e_valid != 0) check(req, "data", int'(ld_rdata), e_data);
    endtask

    task automatic idle(input string req);
        step(req, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R14", "reg", int'(reg_rdata), 0);
        check("R14", "valid", int'(ld_valid), 0);
        check("R14", "data", int'(ld_rdata), 0);
        @(negedge clk); rst_n = 1'b1;

        // R5 plain loads
        step("R5", 0, 0, 1, 16'h0000, 8'h5A);
        step("R5", 0, 0, 1, 16'h0123, 8'hC3);
        idle("R5");

        // R1 R2 R3 R7 R8: arm then load first window cycle, each address
        for (int i = 0; i < 8; i++) begin
            step("R1", 1, 8'h03, 0, 0, 0);
            step("R2_R7_R8_R9", 0, 0, 1, i, 8'h11);
            idle("R3");
        end

        // R9 far reserved address
        step("R1", 1, 8'h03, 0, 0, 0);
        step("R9", 0, 0, 1, 16'h1234, 8'h22);
        step("R9", 0, 0, 1, 16'h0002, 8'h33);

        // R10 load on third cycle, R6 busy visible
        step("R1", 1, 8'hFF, 0, 0, 0);
        idle("R6");
        idle("R6");
        step("R10", 0, 0, 1, 16'h0007, 8'h44);
        idle("R3");

        // R4 expiry, then R10 load on fourth cycle gets flash
        step("R1", 1, 8'h03, 0, 0, 0);
        idle("R4");
        idle("R4");
        idle("R4");
        step("R10", 0, 0, 1, 16'h0000, 8'h66);

        // R11 partial writes
        step("R11", 1, 8'h02, 0, 0, 0);
        step("R11", 0, 0, 1, 16'h0001, 8'h77);
        step("R11", 1, 8'h01, 0, 0, 0);
        step("R11", 0, 0, 1, 16'h0004, 8'h78);
        step("R11", 1, 8'hFC, 0, 0, 0);
        step("R11", 0, 0, 1, 16'h0005, 8'h79);

        // R12 writes while busy: clear attempt and re-arm attempt
        step("R1", 1, 8'h03, 0, 0, 0);
        step("R12", 1, 8'h00, 0, 0, 0);
        step("R12", 1, 8'h03, 0, 0, 0);
        step("R12", 0, 0, 0, 0, 0);
        step("R12", 0, 0, 1, 16'h0000, 8'h88);
        step("R12", 1, 8'h03, 0, 0, 0);
        step("R12", 1, 8'h03, 1, 16'h0004, 8'h99);
        idle("R12");

        // R13 load in same cycle as arming write
        step("R13", 1, 8'h03, 1, 16'h0002, 8'hAB);
        step("R13", 0, 0, 1, 16'h0002, 8'hAC);
        idle("R13");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule